// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a window watchdog for a microcontroller. Software configures it through one 8-bit control register, written over a single-cycle register-write port and read back on a parallel read bus. The register holds three fields. The enable bit can only be set by software. The two-bit period select chooses one of four periods. The restart bit is write-only and serves the watchdog. A 1 ms strobe input paces an internal tick counter.

Each period has two halves. In the first half the window is closed, and a restart write there counts as a fault. In the second half the window is open, and a restart write there is accepted. The block emits a one-cycle reset pulse in two cases: the period runs out with no accepted restart, or a restart arrives while the window is closed. A stop-mode input freezes the count, and the count is cleared when stop mode ends. A sleep-mode input halts the watchdog and drops its enable, so software must enable it again after waking.

Top module: `win_wdog`

## Requirements
- R1: After the synchronous reset `rst`, the read value is 0x00 and `wd_rst_o` is low. The watchdog starts disabled with period select 00.
- R2: Read layout: bit 7 is the enable, bits 6:5 are the period select, and bits 4:0 always read 0. A write updates the period select to bits 6:5 of the written value. The restart bit (bit 0) never reads back as 1.
- R3: Writing 1 to bit 7 sets the enable. Writing 0 to bit 7 leaves it set. Only `rst` or sleep mode clears it.
- R4: The period select maps to a period in ticks of BASE_TICKS × 8 for 00, × 4 for 01, × 2 for 10 and × 1 for 11. The default of 10 ticks gives 80, 40, 20 and 10 ms. With no restart, the reset pulse follows the tick that completes the period.
- R5: A restart write (bit 0 = 1) made while fewer than half the period's ticks have elapsed produces a reset pulse.
- R6: A restart write made once at least half the period's ticks have elapsed produces no pulse. It clears the count, so the next period is full length.
- R7: `wd_rst_o` is high for exactly one cycle, in the cycle after the event. After any pulse, counting resumes from zero and a full period follows.
- R8: While disabled, no pulse occurs, ticks do not advance the count, and restart writes are ignored. After the enable is set, the first pulse comes a full period later.
- R9: While `stop_i` is high, ticks and restarts have no effect and no pulse occurs. In the cycle after `stop_i` falls, the count clears, so a full period follows.
- R10: While `sleep_i` is high, the enable is cleared and stays clear even if written, and no pulse occurs. It stays clear after sleep ends until software sets it again.
- R11: The period select is captured when a period begins, that is, when the count leaves zero. Writing a new select during a period changes the read value at once, but the new period applies only from the next period.
- R12: When a restart write and a tick fall in the same cycle, the restart takes precedence and the tick is discarded. A restart coinciding with the final tick of a period is therefore accepted without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase strobe (1 ms) |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write value |
| rd_data_o | output | 8 | Control register read value |
| stop_i | input | 1 | Stop-mode indication, freezes the count |
| sleep_i | input | 1 | Sleep-mode indication, clears the enable |
| wd_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
Period expiry and servicing can collide: a restart write can land in the very cycle that carries the last tick of a period, and a restart can land together with an ordinary tick inside the closed window. The bench provokes both by driving the write strobe and the tick strobe in one cycle. It judges the outcome by pulse count: no pulse when the count has reached the open half, exactly one pulse when it has not. It then confirms that a full period follows the restart. A near-exhaustive sweep also places a restart at every tick offset of every period select, in a reduced configuration.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;

  typedef logic [1:0] wd_sel_t;

  typedef struct packed {
    logic    en;
    wd_sel_t sel;
  } wd_cfg_t;

  localparam int EN_BIT   = 7;
  localparam int SEL_HI   = 6;
  localparam int SEL_LO   = 5;
  localparam int KICK_BIT = 0;
  localparam int SEL_NUM  = 4;

  // Period in ticks: select 00 gives the longest, each step halves it.
  function automatic int unsigned sel_period(input int unsigned sel, input int unsigned base);
    return base << (SEL_NUM - 1 - sel);
  endfunction

endpackage

// File: rtl/wd_cfg_reg.sv
module wd_cfg_reg
  import win_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       sleep_i,
  output wd_cfg_t    cfg_o,
  output logic       kick_o,
  output logic [7:0] rd_data_o
);

  wd_cfg_t cfg_q;
  logic    unused_rsvd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      if (wr_en_i) begin
        cfg_q.sel <= wr_data_i[SEL_HI:SEL_LO];
      end
      if (sleep_i) begin
        cfg_q.en <= 1'b0;
      end else if (wr_en_i && wr_data_i[EN_BIT]) begin
        cfg_q.en <= 1'b1;
      end
    end
  end

  assign kick_o      = wr_en_i & wr_data_i[KICK_BIT];
  assign unused_rsvd = ^wr_data_i[4:1];
  assign cfg_o       = cfg_q;
  assign rd_data_o   = {cfg_q.en, cfg_q.sel, 5'b00000};

endmodule

// File: rtl/wd_period_sel.sv
module wd_period_sel
  import win_wdog_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 10,
  parameter int unsigned CW         = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  wd_sel_t       sel_i,
  input  logic          at_zero_i,
  output logic [CW-1:0] end_cnt_o,
  output logic [CW-1:0] open_cnt_o
);

  logic [CW-1:0] end_tab  [SEL_NUM];
  logic [CW-1:0] open_tab [SEL_NUM];
  wd_sel_t       cur_sel_q;
  wd_sel_t       eff_sel;

  for (genvar g = 0; g < SEL_NUM; g++) begin : g_tab
    localparam int unsigned PT = sel_period(g, BASE_TICKS);
    assign end_tab[g]  = CW'(PT - 1);
    assign open_tab[g] = CW'(PT / 2);
  end

  // A period takes the select that is current while its count sits at zero.
  assign eff_sel = at_zero_i ? sel_i : cur_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_sel_q <= '0;
    end else begin
      cur_sel_q <= eff_sel;
    end
  end

  assign end_cnt_o  = end_tab[eff_sel];
  assign open_cnt_o = open_tab[eff_sel];

endmodule

// File: rtl/wd_window_ctr.sv
module wd_window_ctr #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          stop_i,
  input  logic          sleep_i,
  input  logic          kick_i,
  input  logic          tick_i,
  input  logic [CW-1:0] end_cnt_i,
  input  logic [CW-1:0] open_cnt_i,
  output logic          at_zero_o,
  output logic          fire_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          stop_q;
  logic          fire;

  always_comb begin
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (!en_i || sleep_i) begin
      cnt_d = '0;
    end else if (stop_i) begin
      cnt_d = cnt_q;
    end else if (stop_q) begin
      cnt_d = '0;
    end else if (kick_i) begin
      cnt_d = '0;
      fire  = (cnt_q < open_cnt_i);
    end else if (tick_i) begin
      if (cnt_q >= end_cnt_i) begin
        cnt_d = '0;
        fire  = 1'b1;
      end else begin
        cnt_d = CW'(cnt_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      stop_q <= stop_i;
    end
  end

  assign at_zero_o = (cnt_q == '0);
  assign fire_o    = fire;

endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import win_wdog_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       stop_i,
  input  logic       sleep_i,
  output logic       wd_rst_o
);

  localparam int unsigned MAX_PERIOD = sel_period(0, BASE_TICKS);
  localparam int unsigned CW         = $clog2(MAX_PERIOD + 1);

  wd_cfg_t       cfg;
  logic          kick;
  logic          at_zero;
  logic          fire;
  logic [CW-1:0] end_cnt;
  logic [CW-1:0] open_cnt;
  logic          pulse_q;

  wd_cfg_reg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .sleep_i   (sleep_i),
    .cfg_o     (cfg),
    .kick_o    (kick),
    .rd_data_o (rd_data_o)
  );

  wd_period_sel #(.BASE_TICKS(BASE_TICKS), .CW(CW)) u_per (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (cfg.sel),
    .at_zero_i  (at_zero),
    .end_cnt_o  (end_cnt),
    .open_cnt_o (open_cnt)
  );

  wd_window_ctr #(.CW(CW)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .en_i       (cfg.en),
    .stop_i     (stop_i),
    .sleep_i    (sleep_i),
    .kick_i     (kick),
    .tick_i     (tick_i),
    .end_cnt_i  (end_cnt),
    .open_cnt_i (open_cnt),
    .at_zero_o  (at_zero),
    .fire_o     (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
    end
  end

  assign wd_rst_o = pulse_q;

endmodule

// File: rtl/wd_win_chk.sv
module wd_win_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       stop_i,
  input logic       sleep_i,
  input logic [7:0] rd_data_o,
  input logic       wd_rst_o
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (rd_data_o == 8'h00 && !wd_rst_o));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[4:0] == 5'b00000);

  p_sel_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> rd_data_o[6:5] == $past(wr_data_i[6:5]));

  p_en_set_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_data_i[7] && !sleep_i) |=> rd_data_o[7]);

  p_en_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o[7] && !sleep_i) |=> rd_data_o[7]);

  p_one_cycle_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    wd_rst_o |=> !wd_rst_o);

  p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_data_o[7] |=> !wd_rst_o);

  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !wd_rst_o);

  p_sleep_clear_r10: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> (!rd_data_o[7] && !wd_rst_o));

endmodule

bind win_wdog wd_win_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .stop_i    (stop_i),
  .sleep_i   (sleep_i),
  .rd_data_o (rd_data_o),
  .wd_rst_o  (wd_rst_o)
);

// File: tb/sim_win_wdog.sv
`timescale 1ns/1ps
module sim_win_wdog;

  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       stop_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       wd_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  int wide = 0;
  logic prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  win_wdog #(.BASE_TICKS(BASE)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .stop_i(stop_i),
    .sleep_i(sleep_i), .wd_rst_o(wd_rst_o)
  );

  always @(negedge clk) begin
    if (wd_rst_o === 1'b1) pulses++;
    if (wd_rst_o === 1'b1 && prev === 1'b1) wide++;
    prev = wd_rst_o;
  end

  function automatic int per(input int s);
    return BASE << (3 - s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input logic [7:0] d, input bit t);
    @(negedge clk);
    wr_en_i = w; wr_data_i = d; tick_i = t;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b1);
  endtask

  task automatic settle();
    cyc(1'b0, 8'h00, 1'b0);
    cyc(1'b0, 8'h00, 1'b0);
    #1;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst = 1'b1; wr_en_i = 1'b0; tick_i = 1'b0; stop_i = 1'b0; sleep_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [7:0] cfg(input int s, input bit kick);
    return {1'b1, 2'(s), 4'b0000, kick};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int base_p;
    hw_reset();
    settle();
    // R1 reset state
    chk(rd_data_o == 8'h00, "R1 read after reset", rd_data_o, 0);
    chk(wd_rst_o == 1'b0, "R1 pulse after reset", wd_rst_o, 0);

    // R8 disabled: restarts and ticks do nothing
    base_p = pulses;
    cyc(1'b1, 8'h01, 1'b0);
    ticks(3 * per(0));
    settle();
    chk(pulses == base_p, "R8 no pulse while disabled", pulses - base_p, 0);
    chk(rd_data_o == 8'h00, "R2 restart bit reads zero", rd_data_o, 0);

    // R2 read layout
    cyc(1'b1, 8'hFF, 1'b0);
    settle();
    chk(rd_data_o == 8'hE0, "R2 read layout", rd_data_o, 8'hE0);
    // R3 enable sticky
    cyc(1'b1, 8'h00, 1'b0);
    settle();
    chk(rd_data_o == 8'h80, "R3 enable kept after writing 0", rd_data_o, 8'h80);

    // R4 R5 R6 R7 sweep: restart after k ticks for every select
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < per(s); k++) begin
        hw_reset();
        cyc(1'b1, cfg(s, 1'b0), 1'b0);
        ticks(k);
        settle();
        base_p = pulses;
        chk(pulses == base_p, "R4 no early expiry", 0, 0);
        cyc(1'b1, cfg(s, 1'b1), 1'b0);
        settle();
        if (k < per(s) / 2)
          chk(pulses == base_p + 1, "R5 closed window restart", pulses - base_p, 1);
        else
          chk(pulses == base_p, "R6 open window restart", pulses - base_p, 0);
        base_p = pulses;
        ticks(per(s) - 1);
        settle();
        chk(pulses == base_p, "R7 full period after restart", pulses - base_p, 0);
        ticks(1);
        settle();
        chk(pulses == base_p + 1, "R4 expiry after period", pulses - base_p, 1);
      end
    end
    chk(wide == 0, "R7 pulse one cycle wide", wide, 0);

    // R8 enable starts a full period
    hw_reset();
    cyc(1'b1, cfg(1, 1'b0), 1'b0);
    base_p = pulses;
    ticks(per(1) - 1);
    settle();
    chk(pulses == base_p, "R8 no pulse before full period", pulses - base_p, 0);
    ticks(1);
    settle();
    chk(pulses == base_p + 1, "R8 pulse after full period", pulses - base_p, 1);

    // R9 stop freezes, wake clears
    hw_reset();
    cyc(1'b1, cfg(1, 1'b0), 1'b0);
    ticks(5);
    @(negedge clk) stop_i = 1'b1;
    base_p = pulses;
    ticks(3 * per(1));
    cyc(1'b1, cfg(1, 1'b1), 1'b0);
    settle();
    chk(pulses == base_p, "R9 frozen in stop", pulses - base_p, 0);
    @(negedge clk) stop_i = 1'b0;
    settle();
    ticks(per(1) - 1);
    settle();
    chk(pulses == base_p, "R9 full period after wake", pulses - base_p, 0);
    ticks(1);
    settle();
    chk(pulses == base_p + 1, "R9 expiry after wake", pulses - base_p, 1);

    // R10 sleep clears enable
    hw_reset();
    cyc(1'b1, cfg(1, 1'b0), 1'b0);
    ticks(3);
    @(negedge clk) sleep_i = 1'b1;
    cyc(1'b1, cfg(1, 1'b0), 1'b0);
    base_p = pulses;
    ticks(2 * per(1));
    settle();
    chk(rd_data_o[7] == 1'b0, "R10 enable clear in sleep", rd_data_o[7], 0);
    @(negedge clk) sleep_i = 1'b0;
    ticks(2 * per(1));
    settle();
    chk(rd_data_o[7] == 1'b0, "R10 enable clear after sleep", rd_data_o[7], 0);
    chk(pulses == base_p, "R10 no pulse across sleep", pulses - base_p, 0);
    cyc(1'b1, cfg(1, 1'b0), 1'b0);
    ticks(per(1));
    settle();
    chk(pulses == base_p + 1, "R10 re-enabled expiry", pulses - base_p, 1);

    // R11 select change deferred to next period
    hw_reset();
    cyc(1'b1, cfg(0, 1'b0), 1'b0);
    ticks(2);
    cyc(1'b1, cfg(3, 1'b0), 1'b0);
    settle();
    chk(rd_data_o == 8'hE0, "R11 new select visible", rd_data_o, 8'hE0);
    base_p = pulses;
    ticks(per(0) - 3);
    settle();
    chk(pulses == base_p, "R11 old period still running", pulses - base_p, 0);
    ticks(1);
    settle();
    chk(pulses == base_p + 1, "R11 old period expiry", pulses - base_p, 1);
    base_p = pulses;
    ticks(per(3) - 1);
    settle();
    chk(pulses == base_p, "R11 new period not yet", pulses - base_p, 0);
    ticks(1);
    settle();
    chk(pulses == base_p + 1, "R11 new period expiry", pulses - base_p, 1);

    // R12 restart together with final tick, and with a closed-window tick
    for (int s = 0; s < 4; s++) begin
      hw_reset();
      cyc(1'b1, cfg(s, 1'b0), 1'b0);
      ticks(per(s) - 1);
      base_p = pulses;
      cyc(1'b1, cfg(s, 1'b1), 1'b1);
      settle();
      chk(pulses == base_p, "R12 restart wins over last tick", pulses - base_p, 0);
      ticks(per(s) - 1);
      settle();
      chk(pulses == base_p, "R12 full period after collision", pulses - base_p, 0);
      ticks(1);
      settle();
      chk(pulses == base_p + 1, "R12 expiry after collision", pulses - base_p, 1);
      base_p = pulses;
      cyc(1'b1, cfg(s, 1'b1), 1'b1);
      settle();
      chk(pulses == base_p + 1, "R12 closed restart with tick", pulses - base_p, 1);
    end
    chk(wide == 0, "R7 pulse width overall", wide, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule